// File: doc/BRIEF.md
# Display-List Command Sequencer

This block walks a chain of fixed-size drawing commands held in video RAM. Each entry is sixteen 16-bit words (32 bytes). The sequencer reads an entry through a read port with one cycle of latency and decodes its control word. It then either hands the command to a drawing engine over a valid/ready handshake, runs it locally, or passes over it. After that it chooses where the next entry lives.

Coordinate and clip commands are run inside the sequencer and update four coordinate registers. Primitive commands (sprites, polygons, lines) go to the engine together with the entry's byte address. The jump mode of each entry selects among the following entry, an absolute link, a call that saves one return address, and a return. A skip flag lets the walk move on without running the current command.

A two-bit trigger register sets when a walk starts. A walk can start once, as soon as the trigger is written, or at every frame tick while the sequencer is idle. Every walk begins at byte address 0. Two status outputs give the byte address of the entry being handled and of the last command actually run.

Top module: `dlist_sequencer`

## Requirements
- R1: The trigger register holds 00 (off), 01 (start now) or 10 (start per frame). While idle, a write of 01 starts a walk at byte address 0 on the next cycle. While the register holds 10, a frame tick starts a walk. A write of 00 or 10 never starts a walk, a frame tick with the register at 00 or 01 starts nothing, and a start request while busy is ignored.
- R2: An entry at byte address A is read as 16 consecutive word reads, one per cycle, at word addresses A/2 through A/2+15. Read data is taken one cycle after each request. Words 0 (control), 1 (link), 6 (XA), 7 (YA), 10 (XC) and 11 (YC) are decoded.
- R3: When control bit 15 is set, the walk ends: busy falls in the next cycle and nothing is dispatched or run for that entry.
- R4: Control bits 13:12 pick the next entry. 00 goes to A+32. 01 goes to LINK×8. 10 goes to LINK×8 and is a call. 11 goes to the saved return address.
- R5: Control bit 14 set means skip. The command is not run, the clip registers and last-run status stay unchanged, and the jump in bits 13:12 is still taken (a skipped call still saves its return address).
- R6: A call saves A+32 in a single return register, which resets to 0. A later call overwrites it before any return.
- R7: Command codes (control bits 3:0) 0, 1, 2, 4, 5 and 6 are dispatched. eng_valid rises with eng_code equal to the code and eng_addr equal to A. Code and address are held until eng_ready, and only then is the next entry fetched.
- R8: Codes 8, 9 and 10 run locally and are never dispatched. Code 8 sets usr_clip_lo={YA,XA} and usr_clip_hi={YC,XC}. Code 9 sets sys_clip_hi={YC,XC}. Code 10 sets local_org={YA,XA}. All four reset to 0.
- R9: Any other code is a no-op. The entry is not dispatched, last_addr is unchanged, and the jump is taken.
- R10: cur_addr is the byte address of the entry in hand and is 0 after reset. last_addr is the address of the last command run, updated when the engine accepts a command or a local command runs, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_we | input | 1 | Trigger register write strobe |
| trig_data | input | 2 | Trigger value written |
| frame_tick | input | 1 | One-cycle frame change pulse |
| ram_rd_en | output | 1 | Video RAM read request |
| ram_addr | output | ADDR_W-1 | Video RAM word address |
| ram_rd_data | input | DW | Read data, valid one cycle after the request |
| eng_valid | output | 1 | Command offered to drawing engine |
| eng_ready | input | 1 | Drawing engine accepts command |
| eng_code | output | 4 | Command code offered |
| eng_addr | output | ADDR_W | Byte address of the offered entry |
| busy | output | 1 | A walk is in progress |
| cur_addr | output | ADDR_W | Byte address of the entry in hand |
| last_addr | output | ADDR_W | Byte address of the last command run |
| usr_clip_lo | output | 2*DW | User clip upper-left {Y,X} |
| usr_clip_hi | output | 2*DW | User clip lower-right {Y,X} |
| sys_clip_hi | output | 2*DW | System clip lower-right {Y,X} |
| local_org | output | 2*DW | Local coordinate origin {Y,X} |

## Verification
The assertions watch for cycle-local rules on every cycle. Fetch addresses must step by one within an entry. A refused engine offer must hold its code and address, and only primitive codes may reach the engine. An end entry must drop busy, and a call must load the return register with the following address. A run must copy the current address into last_addr, the coordinate registers may change only when a local command runs, and a fetch may not be launched while one is active. Whether a chain of jumps, skipped calls, overwritten returns and no-ops visits the right entries in the right order, and leaves the right final coordinate and status values, only shows in the bench's lists, which a behavioural model follows clock by clock.

// File: rtl/dlseq_pkg.sv
`timescale 1ns/1ps
package dlseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DISP  = 2'd3
  } seq_state_e;

  // jump selector (low two bits of the jump field)
  localparam logic [1:0] JMP_NEXT   = 2'b00;
  localparam logic [1:0] JMP_ASSIGN = 2'b01;
  localparam logic [1:0] JMP_CALL   = 2'b10;
  localparam logic [1:0] JMP_RETURN = 2'b11;

  // trigger register values
  localparam logic [1:0] TRIG_OFF   = 2'd0;
  localparam logic [1:0] TRIG_NOW   = 2'd1;
  localparam logic [1:0] TRIG_FRAME = 2'd2;

  // control word bit positions
  localparam int unsigned CB_END  = 15;
  localparam int unsigned CB_SKIP = 14;

  // words of an entry that the sequencer keeps
  localparam int unsigned N_KEEP    = 6;
  localparam int unsigned SLOT_CTRL = 0;
  localparam int unsigned SLOT_LINK = 1;
  localparam int unsigned SLOT_XA   = 2;
  localparam int unsigned SLOT_YA   = 3;
  localparam int unsigned SLOT_XC   = 4;
  localparam int unsigned SLOT_YC   = 5;
  localparam int unsigned KEEP_IDX [N_KEEP] = '{0, 1, 6, 7, 10, 11};

  // command codes
  localparam logic [3:0] OP_SPRITE    = 4'd0;
  localparam logic [3:0] OP_SCALED    = 4'd1;
  localparam logic [3:0] OP_DISTORT   = 4'd2;
  localparam logic [3:0] OP_POLYGON   = 4'd4;
  localparam logic [3:0] OP_POLYLINE  = 4'd5;
  localparam logic [3:0] OP_LINE      = 4'd6;
  localparam logic [3:0] OP_USER_CLIP = 4'd8;
  localparam logic [3:0] OP_SYS_CLIP  = 4'd9;
  localparam logic [3:0] OP_LOCAL     = 4'd10;

  function automatic logic op_is_draw(input logic [3:0] op);
    return op inside {OP_SPRITE, OP_SCALED, OP_DISTORT, OP_POLYGON, OP_POLYLINE, OP_LINE};
  endfunction

  function automatic logic op_is_internal(input logic [3:0] op);
    return op inside {OP_USER_CLIP, OP_SYS_CLIP, OP_LOCAL};
  endfunction

endpackage

// File: rtl/dl_fetch.sv
`timescale 1ns/1ps
module dl_fetch
  import dlseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DW     = 16,
  parameter int unsigned NWORDS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  input  logic [ADDR_W-2:0]            go_waddr,
  output logic                         rd_en,
  output logic [ADDR_W-2:0]            rd_addr,
  input  logic [DW-1:0]                rd_data,
  output logic [N_KEEP-1:0][DW-1:0]    kept,
  output logic                         last_beat,
  output logic                         active
);
  localparam int unsigned WA_W  = ADDR_W - 1;
  localparam int unsigned CNT_W = $clog2(NWORDS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NWORDS);

  logic [CNT_W-1:0] cnt_q;
  logic [WA_W-1:0]  base_q;
  logic             active_q;

  assign active    = active_q;
  assign rd_en     = active_q && (cnt_q < CNT_LAST);
  assign rd_addr   = base_q + WA_W'(cnt_q);
  assign last_beat = active_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      base_q   <= go_waddr;
    end else if (active_q) begin
      if (cnt_q == CNT_LAST) active_q <= 1'b0;
      else                   cnt_q    <= cnt_q + 1'b1;
    end
  end

  // keep only the decoded words; data of request k arrives while cnt is k+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept <= '0;
    end else begin
      for (int s = 0; s < N_KEEP; s++) begin
        if (active_q && cnt_q == CNT_W'(KEEP_IDX[s] + 1)) kept[s] <= rd_data;
      end
    end
  end

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cnt_q != '0) |-> rd_addr == WA_W'($past(rd_addr) + 1'b1));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active_q);

endmodule

// File: rtl/dl_decode.sv
`timescale 1ns/1ps
module dl_decode
  import dlseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned DW          = 16,
  parameter int unsigned ENTRY_BYTES = 32
) (
  input  logic [DW-1:0]     ctrl,
  input  logic [DW-1:0]     link,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic              end_f,
  output logic              skip_f,
  output logic [1:0]        jmp,
  output logic [3:0]        op,
  output logic              draw_f,
  output logic              intl_f,
  output logic [ADDR_W-1:0] nxt_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ENTRY_BYTES);

  function automatic logic [ADDR_W-1:0] link_to_byte(input logic [DW-1:0] l);
    return ADDR_W'({l, 3'b000});
  endfunction

  function automatic logic [ADDR_W-1:0] pick_next(
    input logic [1:0] j, input logic [ADDR_W-1:0] cur,
    input logic [DW-1:0] l, input logic [ADDR_W-1:0] ret);
    case (j)
      JMP_NEXT:   return cur + STEP;
      JMP_ASSIGN: return link_to_byte(l);
      JMP_CALL:   return link_to_byte(l);
      default:    return ret;
    endcase
  endfunction

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^ctrl[11:4];

  assign end_f    = ctrl[CB_END];
  assign skip_f   = ctrl[CB_SKIP];
  assign jmp      = ctrl[13:12];
  assign op       = ctrl[3:0];
  assign draw_f   = op_is_draw(op);
  assign intl_f   = op_is_internal(op);
  assign nxt_addr = pick_next(jmp, cur_addr, link, ret_addr);

endmodule

// File: rtl/dl_coord.sv
`timescale 1ns/1ps
module dl_coord
  import dlseq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [3:0]      op,
  input  logic [DW-1:0]   xa,
  input  logic [DW-1:0]   ya,
  input  logic [DW-1:0]   xc,
  input  logic [DW-1:0]   yc,
  output logic [2*DW-1:0] usr_lo,
  output logic [2*DW-1:0] usr_hi,
  output logic [2*DW-1:0] sys_hi,
  output logic [2*DW-1:0] loc_org
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_lo  <= '0;
      usr_hi  <= '0;
      sys_hi  <= '0;
      loc_org <= '0;
    end else if (we) begin
      case (op)
        OP_USER_CLIP: begin
          usr_lo <= {ya, xa};
          usr_hi <= {yc, xc};
        end
        OP_SYS_CLIP: sys_hi  <= {yc, xc};
        OP_LOCAL:    loc_org <= {ya, xa};
        default: ;
      endcase
    end
  end

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(usr_lo) && $stable(usr_hi) && $stable(sys_hi) && $stable(loc_org)));

endmodule

// File: rtl/dlist_sequencer.sv
`timescale 1ns/1ps
module dlist_sequencer
  import dlseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DW     = 16,
  parameter int unsigned NWORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [1:0]        trig_data,
  input  logic              frame_tick,
  output logic              ram_rd_en,
  output logic [ADDR_W-2:0] ram_addr,
  input  logic [DW-1:0]     ram_rd_data,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [3:0]        eng_code,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] last_addr,
  output logic [2*DW-1:0]   usr_clip_lo,
  output logic [2*DW-1:0]   usr_clip_hi,
  output logic [2*DW-1:0]   sys_clip_hi,
  output logic [2*DW-1:0]   local_org
);
  localparam int unsigned ENTRY_BYTES = NWORDS * (DW / 8);
  localparam logic [ADDR_W-1:0] ENTRY_STEP = ADDR_W'(ENTRY_BYTES);

  seq_state_e state_q, state_d;
  logic [1:0]        trig_q;
  logic [ADDR_W-1:0] cur_q, nxt_q, ret_q, last_q;

  logic [N_KEEP-1:0][DW-1:0] kept;
  logic last_beat, fetch_active;

  logic              end_f, skip_f, draw_f, intl_f;
  logic [1:0]        jmp;
  logic [3:0]        op;
  logic [ADDR_W-1:0] nxt_addr;

  // named events
  logic start, in_exec, exec_end, exec_call, exec_pass, exec_intl, exec_draw;
  logic disp_acc, cmd_run, go;
  logic [ADDR_W-1:0] go_byte;

  assign start     = (state_q == ST_IDLE) &&
                     ((trig_we && trig_data == TRIG_NOW) || (trig_q == TRIG_FRAME && frame_tick));
  assign in_exec   = (state_q == ST_EXEC);
  assign exec_end  = in_exec && end_f;
  assign exec_call = in_exec && !end_f && (jmp == JMP_CALL);
  assign exec_pass = in_exec && !end_f && (skip_f || (!draw_f && !intl_f));
  assign exec_intl = in_exec && !end_f && !skip_f && intl_f;
  assign exec_draw = in_exec && !end_f && !skip_f && draw_f;
  assign disp_acc  = (state_q == ST_DISP) && eng_ready;
  assign cmd_run   = exec_intl || disp_acc;
  assign go        = start || exec_pass || exec_intl || disp_acc;
  assign go_byte   = start ? '0 : (in_exec ? nxt_addr : nxt_q);

  dl_fetch #(.ADDR_W(ADDR_W), .DW(DW), .NWORDS(NWORDS)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_waddr  (go_byte[ADDR_W-1:1]),
    .rd_en     (ram_rd_en),
    .rd_addr   (ram_addr),
    .rd_data   (ram_rd_data),
    .kept      (kept),
    .last_beat (last_beat),
    .active    (fetch_active)
  );

  dl_decode #(.ADDR_W(ADDR_W), .DW(DW), .ENTRY_BYTES(ENTRY_BYTES)) u_dec (
    .ctrl     (kept[SLOT_CTRL]),
    .link     (kept[SLOT_LINK]),
    .cur_addr (cur_q),
    .ret_addr (ret_q),
    .end_f    (end_f),
    .skip_f   (skip_f),
    .jmp      (jmp),
    .op       (op),
    .draw_f   (draw_f),
    .intl_f   (intl_f),
    .nxt_addr (nxt_addr)
  );

  dl_coord #(.DW(DW)) u_coord (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (exec_intl),
    .op      (op),
    .xa      (kept[SLOT_XA]),
    .ya      (kept[SLOT_YA]),
    .xc      (kept[SLOT_XC]),
    .yc      (kept[SLOT_YC]),
    .usr_lo  (usr_clip_lo),
    .usr_hi  (usr_clip_hi),
    .sys_hi  (sys_clip_hi),
    .loc_org (local_org)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_FETCH;
      ST_FETCH: if (last_beat) state_d = ST_EXEC;
      ST_EXEC: begin
        if (exec_end)       state_d = ST_IDLE;
        else if (exec_draw) state_d = ST_DISP;
        else                state_d = ST_FETCH;
      end
      ST_DISP:  if (eng_ready) state_d = ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trig_q  <= TRIG_OFF;
      cur_q   <= '0;
      nxt_q   <= '0;
      ret_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      if (trig_we)   trig_q <= trig_data;
      if (go)        cur_q  <= go_byte;
      if (in_exec)   nxt_q  <= nxt_addr;
      if (exec_call) ret_q  <= cur_q + ENTRY_STEP;
      if (cmd_run)   last_q <= cur_q;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign eng_valid = (state_q == ST_DISP);
  assign eng_code  = op;
  assign eng_addr  = cur_q;
  assign cur_addr  = cur_q;
  assign last_addr = last_q;

  a_r1_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !exec_end) |=> busy);

  a_r3_end_idles: assert property (@(posedge clk) disable iff (!rst_n)
    exec_end |=> (!busy && !eng_valid && !ram_rd_en));

  a_r6_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
    exec_call |=> ret_q == ADDR_W'($past(cur_q) + ENTRY_STEP));

  a_r7_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_code) && $stable(eng_addr)));

  a_r7_only_draw: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> op_is_draw(eng_code));

  a_r9_noop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && !end_f && !draw_f && !intl_f) |=> (!eng_valid && $stable(last_addr)));

  a_r10_last_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_run |=> last_addr == $past(cur_addr));

  a_r2_fetch_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |-> (state_q == ST_FETCH && fetch_active));

endmodule

// File: tb/sim_dlist_sequencer.sv
`timescale 1ns/1ps
module sim_dlist_sequencer;
  localparam int AW = 19;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic trig_we = 1'b0;
  logic [1:0] trig_data = 2'd0;
  logic frame_tick = 1'b0;
  logic ram_rd_en;
  logic [AW-2:0] ram_addr;
  logic [DW-1:0] ram_rd_data = '0;
  logic eng_valid, eng_ready = 1'b1;
  logic [3:0] eng_code;
  logic [AW-1:0] eng_addr, cur_addr, last_addr;
  logic busy;
  logic [2*DW-1:0] usr_clip_lo, usr_clip_hi, sys_clip_hi, local_org;

  dlist_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_data(trig_data),
    .frame_tick(frame_tick), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
    .ram_rd_data(ram_rd_data), .eng_valid(eng_valid), .eng_ready(eng_ready),
    .eng_code(eng_code), .eng_addr(eng_addr), .busy(busy), .cur_addr(cur_addr),
    .last_addr(last_addr), .usr_clip_lo(usr_clip_lo), .usr_clip_hi(usr_clip_hi),
    .sys_clip_hi(sys_clip_hi), .local_org(local_org)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // video RAM: one cycle read latency
  logic [15:0] mem [0:4095];
  always @(posedge clk) if (ram_rd_en) ram_rd_data <= mem[ram_addr[11:0]];

  function automatic int mw(input int baddr, input int k);
    return int'(mem[((baddr >> 1) + k) & 4095]);
  endfunction

  // behavioural reference: phase 0 idle, 1 reading, 2 deciding, 3 offering
  int m_ph, m_cnt, m_cur, m_last, m_ret, m_trig, m_nxt;
  logic [31:0] m_ulo, m_uhi, m_shi, m_loc;

  always @(posedge clk) begin : model
    int ctrl, code, jp, nxt;
    bit st;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_cur = 0; m_last = 0; m_ret = 0; m_trig = 0; m_nxt = 0;
      m_ulo = 0; m_uhi = 0; m_shi = 0; m_loc = 0;
    end else begin
      st = (m_ph == 0) && ((trig_we && trig_data == 2'd1) || (m_trig == 2 && frame_tick));
      if (trig_we) m_trig = int'(trig_data);
      case (m_ph)
        0: if (st) begin m_ph = 1; m_cnt = 0; m_cur = 0; end
        1: if (m_cnt == 16) m_ph = 2; else m_cnt++;
        2: begin
          ctrl = mw(m_cur, 0);
          code = ctrl & 15;
          jp = (ctrl >> 12) & 3;
          if (((ctrl >> 15) & 1) == 1) m_ph = 0;
          else begin
            if (jp == 0) nxt = m_cur + 32;
            else if (jp == 3) nxt = m_ret;
            else nxt = mw(m_cur, 1) * 8;
            nxt = nxt & 'h7FFFF;
            if (jp == 2) m_ret = (m_cur + 32) & 'h7FFFF;
            if (((ctrl >> 14) & 1) == 1 || !(code inside {0,1,2,4,5,6,8,9,10})) begin
              m_ph = 1; m_cnt = 0; m_cur = nxt;
            end else if (code >= 8) begin
              if (code == 8) begin
                m_ulo = {mw(m_cur,7) & 16'hFFFF, 16'h0} | 32'(mw(m_cur,6));
                m_uhi = {mw(m_cur,11) & 16'hFFFF, 16'h0} | 32'(mw(m_cur,10));
              end else if (code == 9) begin
                m_shi = {mw(m_cur,11) & 16'hFFFF, 16'h0} | 32'(mw(m_cur,10));
              end else begin
                m_loc = {mw(m_cur,7) & 16'hFFFF, 16'h0} | 32'(mw(m_cur,6));
              end
              m_last = m_cur; m_ph = 1; m_cnt = 0; m_cur = nxt;
            end else begin
              m_ph = 3; m_nxt = nxt;
            end
          end
        end
        default: if (eng_ready) begin
          m_last = m_cur; m_ph = 1; m_cnt = 0; m_cur = m_nxt;
        end
      endcase
    end
  end

  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R1/R3 busy", busy, m_ph != 0);
      chk("R2 rd_en", ram_rd_en, (m_ph == 1 && m_cnt < 16));
      if (m_ph == 1 && m_cnt < 16) chk("R2 ram_addr", ram_addr, ((m_cur >> 1) + m_cnt) & 'h3FFFF);
      chk("R7 eng_valid", eng_valid, m_ph == 3);
      if (m_ph == 3) begin
        chk("R7 eng_code", eng_code, mw(m_cur, 0) & 15);
        chk("R7 eng_addr", eng_addr, m_cur);
      end
      chk("R10 cur_addr", cur_addr, m_cur);
      chk("R10 last_addr", last_addr, m_last);
      chk("R8 usr_clip_lo", usr_clip_lo, m_ulo);
      chk("R8 usr_clip_hi", usr_clip_hi, m_uhi);
      chk("R8 sys_clip_hi", sys_clip_hi, m_shi);
      chk("R8 local_org", local_org, m_loc);
    end
  end

  // engine stub: ready always, or one cycle in three
  bit slow_eng = 1'b0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    #1 eng_ready = slow_eng ? (cyc % 3 == 0) : 1'b1;
  end

  int acc[$];
  always @(posedge clk) if (rst_n && eng_valid && eng_ready) acc.push_back(int'(eng_addr));

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic put(input int baddr, input logic [15:0] ctrl, input logic [15:0] link,
                     input logic [15:0] xa, input logic [15:0] ya,
                     input logic [15:0] xc, input logic [15:0] yc);
    for (int k = 0; k < 16; k++) mem[((baddr >> 1) + k) & 4095] = 16'hA500 + 16'(k);
    mem[(baddr >> 1) + 0]  = ctrl;
    mem[(baddr >> 1) + 1]  = link;
    mem[(baddr >> 1) + 6]  = xa;
    mem[(baddr >> 1) + 7]  = ya;
    mem[(baddr >> 1) + 10] = xc;
    mem[(baddr >> 1) + 11] = yc;
  endtask

  task automatic wr_trig(input logic [1:0] v);
    @(negedge clk); #1 trig_we = 1'b1; trig_data = v;
    @(negedge clk); #1 trig_we = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); #1 frame_tick = 1'b1;
    @(negedge clk); #1 frame_tick = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=busy expected=idle");
    summary();
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R10 reset cur_addr", cur_addr, 0);
    chk("R10 reset last_addr", last_addr, 0);
    chk("R1 reset busy", busy, 0);
    chk("R8 reset usr_clip_lo", usr_clip_lo, 0);
    cmp_on = 1'b1;

    // list A: local commands, one primitive, an undefined code, end
    put('h00, 16'h0008, 0, 5, 6, 319, 239);
    put('h20, 16'h0009, 0, 0, 0, 300, 200);
    put('h40, 16'h000A, 0, 16, 32, 0, 0);
    put('h60, 16'h0004, 0, 50, 50, 150, 150);
    put('h80, 16'h0003, 0, 0, 0, 0, 0);
    put('hA0, 16'h8000, 0, 0, 0, 0, 0);
    slow_eng = 1'b1;
    acc.delete();
    wr_trig(2'd1);
    chk("R1 start now busy", busy, 1);
    wait_idle();
    chk("R8 user clip lo", usr_clip_lo, 32'h0006_0005);
    chk("R8 user clip hi", usr_clip_hi, 32'h00EF_013F);
    chk("R8 system clip", sys_clip_hi, 32'h00C8_012C);
    chk("R8 local origin", local_org, 32'h0020_0010);
    chk("R9 last skips no-op", last_addr, 'h60);
    chk("R7 one dispatch", acc.size(), 1);
    if (acc.size() > 0) chk("R7 dispatched addr", acc[0], 'h60);
    chk("R3 stop at end entry", cur_addr, 'hA0);

    // list B: calls, skips, returns, assigns; per-frame start
    clear_mem();
    put('h000, 16'h2006, 16'h0020, 0, 0, 0, 0);
    put('h100, 16'h4004, 0, 0, 0, 0, 0);
    put('h120, 16'h3005, 0, 0, 0, 0, 0);
    put('h020, 16'h1000, 16'h0040, 0, 0, 0, 0);
    put('h200, 16'h6004, 16'h0060, 0, 0, 0, 0);
    put('h300, 16'h2008, 16'h0080, 7, 8, 100, 90);
    put('h400, 16'h3009, 0, 0, 0, 50, 60);
    put('h320, 16'h8000, 0, 0, 0, 0, 0);
    slow_eng = 1'b0;
    acc.delete();
    wr_trig(2'd0);
    pulse_frame();
    repeat (3) @(negedge clk);
    chk("R1 frame tick ignored when off", busy, 0);
    wr_trig(2'd2);
    chk("R1 writing frame mode does not start", busy, 0);
    pulse_frame();
    chk("R1 frame tick starts", busy, 1);
    repeat (30) @(negedge clk);
    pulse_frame();
    wait_idle();
    chk("R4 dispatch count", acc.size(), 3);
    if (acc.size() == 3) begin
      chk("R4 call target order", acc[0], 'h000);
      chk("R5 skip then return entry", acc[1], 'h120);
      chk("R4 return then assign", acc[2], 'h020);
    end
    chk("R6 second call overwrote return", cur_addr, 'h320);
    chk("R10 last run", last_addr, 'h400);
    chk("R8 call-site user clip", usr_clip_lo, 32'h0008_0007);
    chk("R8 return-site system clip", sys_clip_hi, 32'h003C_0032);

    // list C: skipped clip and undefined code leave state alone
    clear_mem();
    put('h00, 16'h4008, 0, 1, 1, 1, 1);
    put('h20, 16'h000B, 0, 2, 2, 2, 2);
    put('h40, 16'h8000, 0, 0, 0, 0, 0);
    acc.delete();
    wr_trig(2'd1);
    wr_trig(2'd1);
    wait_idle();
    chk("R5 skipped clip leaves user clip", usr_clip_lo, 32'h0008_0007);
    chk("R5 skipped clip leaves hi", usr_clip_hi, 32'h005A_0064);
    chk("R9 undefined leaves last", last_addr, 'h400);
    chk("R9 nothing dispatched", acc.size(), 0);
    chk("R3 ends at end entry", cur_addr, 'h40);
    repeat (4) @(negedge clk);
    chk("R1 no restart in one-shot mode", busy, 0);

    summary();
    $finish;
  end

endmodule